// File: doc/BRIEF.md
# Two-Bank I2C Register Target

This block is an I2C target that connects a bus controller to an 8-bit register store. The store holds two banks of 256 registers. The block takes SCL and SDA already synchronised to the system clock, and it pulls SDA low through an open-drain enable. It oversamples both lines to find clock edges and START and STOP conditions. It answers two adjacent 7-bit addresses. The upper part of the address is fixed, and four bits come from strap pins. The lowest address bit picks the bank for that transaction.

A controller writes a register address byte, which loads an internal pointer. It then either sends one data byte to write, or issues a repeated START and reads one byte back. A set of measurement registers can also be read as a 16-bit pair when the pair-read input is high:

- Both bytes are captured in one clock cycle, so the pair is consistent.
- The low byte is returned first.
- Measurement registers are write-protected.
- A single-byte read of a measurement register is allowed but raises a warning pulse.

The store returns two bytes for each address: the byte at that address and the byte at the next address.

Top module: `i2c_quad_regslave`

## Requirements
- R1: The target acknowledges an address byte whose top two bits are 01 and whose next four bits equal `addr_strap`. Bit 0 of the address byte is the R/W flag, with 1 meaning read. Any other address is left unacknowledged, and the rest of that transaction has no effect.
- R2: Bit 1 of the address byte (A0) selects the bank. `reg_bank` carries A0 for every access of the transaction.
- R3: The sequence START, address with W, pointer byte, data byte produces exactly one single-cycle `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the data byte. Every byte is acknowledged.
- R4: The pointer keeps its value after a STOP. A later read (START, address with R) returns the byte at the pointer, `reg_rdata[7:0]`, most significant bit first.
- R5: The measurement registers are those whose upper nibble is 1 to 4 and whose lower nibble is 9 to C. A write to one of them is acknowledged but raises no `reg_wr`.
- R6: With `pair_mode` high and the pointer on a measurement register, a read returns `reg_rdata[7:0]` then `reg_rdata[15:8]`. Both bytes are captured when the first byte is loaded. The target releases SDA after the controller's NACK.
- R7: With `pair_mode` high and the pointer outside the measurement registers, the target leaves the read address unacknowledged.
- R8: A single-byte read of a measurement register returns its current byte and raises `meas_warn` for one cycle.
- R9: A STOP in the middle of a byte aborts the transaction with no write. A START in the middle of a byte restarts address reception from bit 0.
- R10: The target asserts `sda_pull` only while SCL is low, and it releases SDA within one clock after a STOP.
- R11: After reset, SDA is released, `reg_wr` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| addr_strap | input | 4 | Strap bits of the target address |
| pair_mode | input | 1 | 1 = reads return a 16-bit measurement pair |
| sda_pull | output | 1 | 1 = pull SDA low |
| reg_bank | output | 1 | Bank selected by address bit A0 |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 16 | Byte at reg_addr (low) and at reg_addr+1 (high) |
| meas_warn | output | 1 | Pulse: single-byte read of a measurement register |

## Verification
A corrupted bit counter or state shows up within one byte. It appears as an acknowledge in the wrong bit slot, or as read data shifted by one position. A stale pointer or bank shows up in the next read-back. A shadow capture at the wrong time shows up as a high byte that follows a change made to the store after the low byte was loaded. A missing protection gate shows up as a measurement register that changes after a write.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ACK, ST_PTR, ST_WDATA, ST_RDATA, ST_MACK, ST_WAIT
   } qsl_state_e;

   typedef enum logic [1:0] {
      NX_PTR, NX_WDATA, NX_RDATA, NX_WAIT
   } qsl_next_e;
endpackage

// File: rtl/qsl_line_mon.sv
module qsl_line_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/qsl_meas_decode.sv
module qsl_meas_decode #(
   parameter int GRP_FIRST = 1,
   parameter int GRP_LAST  = 4,
   parameter int NIB_LO    = 9,
   parameter int NIB_HI    = 12
) (
   input  logic [7:0] addr,
   output logic       hit
);
   localparam int NGRP = GRP_LAST - GRP_FIRST + 1;

   if (GRP_LAST < GRP_FIRST || GRP_LAST > 15 || NIB_HI < NIB_LO || NIB_HI > 15) begin : g_bad
      $error("qsl_meas_decode: measurement window out of range");
   end

   logic            nib_ok;
   logic [NGRP-1:0] grp_hit;

   assign nib_ok = (addr[3:0] >= 4'(NIB_LO)) && (addr[3:0] <= 4'(NIB_HI));

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_hit[g] = nib_ok && (addr[7:4] == 4'(GRP_FIRST + g));
   end

   assign hit = |grp_hit;
endmodule

// File: rtl/i2c_quad_regslave.sv
module i2c_quad_regslave #(
   parameter int                      ADDR_FIXED_W   = 2,
   parameter logic [ADDR_FIXED_W-1:0] ADDR_FIXED     = 2'b01,
   parameter int                      STRAP_W        = 4,
   parameter int                      MEAS_GRP_FIRST = 1,
   parameter int                      MEAS_GRP_LAST  = 4,
   parameter int                      MEAS_NIB_LO    = 9,
   parameter int                      MEAS_NIB_HI    = 12,
   parameter bit                      PROTECT_MEAS   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] addr_strap,
   input  logic               pair_mode,
   output logic               sda_pull,
   output logic               reg_bank,
   output logic [7:0]         reg_addr,
   output logic               reg_wr,
   output logic [7:0]         reg_wdata,
   input  logic [15:0]        reg_rdata,
   output logic               meas_warn
);
   import qsl_pkg::*;

   localparam int CNT_W = $clog2(BYTE_W + 1);

   if (ADDR_FIXED_W + STRAP_W != 6) begin : g_bad_addr
      $error("i2c_quad_regslave: fixed + strap bits must total 6");
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   logic ptr_meas, wr_block;

   qsl_line_mon u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   qsl_meas_decode #(
      .GRP_FIRST(MEAS_GRP_FIRST), .GRP_LAST(MEAS_GRP_LAST),
      .NIB_LO(MEAS_NIB_LO), .NIB_HI(MEAS_NIB_HI)
   ) u_dec (
      .addr(reg_addr), .hit(ptr_meas)
   );

   if (PROTECT_MEAS) begin : g_ro
      assign wr_block = ptr_meas;
   end else begin : g_rw
      assign wr_block = 1'b0;
   end

   qsl_state_e        state;
   qsl_next_e         nxt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] rx_byte;
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] hi_shadow;
   logic [CNT_W-1:0]  bit_cnt;
   logic              ack_on, wide, byte_idx, mack_more;
   logic              addr_hit;

   assign rx_byte  = {rx_sh, sda_i};
   assign addr_hit = (rx_byte[BYTE_W-1 -: ADDR_FIXED_W] == ADDR_FIXED)
                  && (rx_byte[2 +: STRAP_W] == addr_strap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         nxt       <= NX_WAIT;
         rx_sh     <= '0;
         tx_sh     <= '0;
         hi_shadow <= '0;
         bit_cnt   <= '0;
         ack_on    <= 1'b0;
         wide      <= 1'b0;
         byte_idx  <= 1'b0;
         mack_more <= 1'b0;
         sda_pull  <= 1'b0;
         reg_bank  <= 1'b0;
         reg_addr  <= '0;
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
         meas_warn <= 1'b0;
      end else begin
         reg_wr    <= 1'b0;
         meas_warn <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            ack_on   <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            ack_on   <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_sh <= rx_byte[BYTE_W-2:0];
                     if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                           if (addr_hit && (!rx_byte[0] || !pair_mode || ptr_meas)) begin
                              reg_bank <= rx_byte[1];
                              wide     <= pair_mode & rx_byte[0];
                              nxt      <= rx_byte[0] ? NX_RDATA : NX_PTR;
                              state    <= ST_ACK;
                           end else begin
                              state <= ST_WAIT;
                           end
                        end else if (state == ST_PTR) begin
                           reg_addr <= rx_byte;
                           nxt      <= NX_WDATA;
                           state    <= ST_ACK;
                        end else begin
                           reg_wdata <= rx_byte;
                           reg_wr    <= ~wr_block;
                           nxt       <= NX_WAIT;
                           state     <= ST_ACK;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (!ack_on) begin
                        sda_pull <= 1'b1;
                        ack_on   <= 1'b1;
                     end else begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        unique case (nxt)
                           NX_PTR:   begin state <= ST_PTR;   sda_pull <= 1'b0; end
                           NX_WDATA: begin state <= ST_WDATA; sda_pull <= 1'b0; end
                           NX_WAIT:  begin state <= ST_WAIT;  sda_pull <= 1'b0; end
                           NX_RDATA: begin
                              tx_sh     <= reg_rdata[BYTE_W-1:0];
                              hi_shadow <= reg_rdata[2*BYTE_W-1:BYTE_W];
                              sda_pull  <= ~reg_rdata[BYTE_W-1];
                              byte_idx  <= 1'b0;
                              meas_warn <= ~wide & ptr_meas;
                              state     <= ST_RDATA;
                           end
                           default: state <= ST_WAIT;
                        endcase
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == CNT_W'(BYTE_W)) begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_MACK;
                     end else begin
                        tx_sh    <= tx_sh << 1;
                        sda_pull <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_more <= ~sda_i & wide & ~byte_idx;
                  end else if (scl_fall) begin
                     mack_more <= 1'b0;
                     if (mack_more) begin
                        tx_sh    <= hi_shadow;
                        sda_pull <= ~hi_shadow[BYTE_W-1];
                        byte_idx <= 1'b1;
                        state    <= ST_RDATA;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/qsl_checker.sv
module qsl_checker #(
   parameter int GRP_FIRST = 1,
   parameter int GRP_LAST  = 4,
   parameter int NIB_LO    = 9,
   parameter int NIB_HI    = 12,
   parameter bit PROTECT   = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       sda_pull,
   input logic       reg_wr,
   input logic [7:0] reg_addr,
   input logic       meas_warn
);
   function automatic logic in_window(input logic [7:0] a);
      int grp, nib;
      grp = int'(a[7:4]);
      nib = int'(a[3:0]);
      return (grp >= GRP_FIRST) && (grp <= GRP_LAST) && (nib >= NIB_LO) && (nib <= NIB_HI);
   endfunction

   AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !$past(scl_i)); // R10

   AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull); // R10

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr); // R3

   AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (PROTECT && reg_wr) |-> !in_window(reg_addr)); // R5

   AST_WARN_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
      meas_warn |-> in_window(reg_addr)); // R8

   AST_WARN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      meas_warn |=> !meas_warn); // R8
endmodule

bind i2c_quad_regslave qsl_checker #(
   .GRP_FIRST(MEAS_GRP_FIRST), .GRP_LAST(MEAS_GRP_LAST),
   .NIB_LO(MEAS_NIB_LO), .NIB_HI(MEAS_NIB_HI), .PROTECT(PROTECT_MEAS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sda_pull(sda_pull), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .meas_warn(meas_warn)
);

// File: tb/sim_i2c_quad_regslave.sv
`timescale 1ns/1ps
module sim_i2c_quad_regslave;
   localparam int Q = 4;
   localparam logic [3:0] STRAP = 4'b1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic pair_mode = 1'b0;
   logic sda_pull, reg_bank, reg_wr, meas_warn;
   logic [7:0] reg_addr, reg_wdata;
   logic [15:0] reg_rdata;
   logic sda_bus;

   int n_chk = 0, n_bad = 0;
   int wr_cnt = 0, warn_cnt = 0, r10_viol = 0;
   bit done = 1'b0;

   logic [7:0] mem [2][256];
   logic [7:0] exp_mem [2][256];
   logic       poke_en = 1'b0, poke_bank = 1'b0;
   logic [7:0] poke_addr = '0, poke_data = '0;
   logic       pull_q = 1'b0, scl_q = 1'b1;

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;
   logic [7:0] nxt_a;
   assign nxt_a = reg_addr + 8'd1;
   assign reg_rdata = {mem[reg_bank][nxt_a], mem[reg_bank][reg_addr]};

   i2c_quad_regslave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .addr_strap(STRAP), .pair_mode(pair_mode), .sda_pull(sda_pull),
      .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .meas_warn(meas_warn)
   );

   always @(posedge clk) begin
      if (reg_wr) begin
         mem[reg_bank][reg_addr] <= reg_wdata;
         wr_cnt <= wr_cnt + 1;
      end else if (poke_en) begin
         mem[poke_bank][poke_addr] <= poke_data;
      end
      if (meas_warn) warn_cnt <= warn_cnt + 1;
      if (rst_n && sda_pull && !pull_q && scl_q) r10_viol <= r10_viol + 1;
      pull_q <= sda_pull;
      scl_q  <= scl_m;
   end

   function automatic logic is_meas(input logic [7:0] a);
      return (a[7:4] >= 4'd1) && (a[7:4] <= 4'd4) && (a[3:0] >= 4'd9) && (a[3:0] <= 4'd12);
   endfunction

   function automatic logic [7:0] dev(input logic bank, input logic rd);
      return {2'b01, STRAP, bank, rd};
   endfunction

   function automatic logic [7:0] init_val(input int b, input int a);
      return 8'(a * 7 + 3) ^ (b != 0 ? 8'hA5 : 8'h3C);
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic do_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic nk);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(nk);
   endtask

   task automatic rbyte(input logic nack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) bit_in(b[i]);
      bit_out(nack);
   endtask

   task automatic poke(input logic b, input logic [7:0] a, input logic [7:0] d);
      poke_bank = b; poke_addr = a; poke_data = d; poke_en = 1'b1;
      wq(1); poke_en = 1'b0;
   endtask

   task automatic do_write(input logic b, input logic [7:0] a, input logic [7:0] d, output logic nk_any);
      logic n1, n2, n3;
      do_start(); wbyte(dev(b, 1'b0), n1); wbyte(a, n2); wbyte(d, n3); do_stop();
      nk_any = n1 | n2 | n3;
   endtask

   task automatic do_read(input logic b, input logic [7:0] a, output logic [7:0] d, output logic nk_any);
      logic n1, n2, n3;
      d = '0;
      do_start(); wbyte(dev(b, 1'b0), n1); wbyte(a, n2);
      do_start(); wbyte(dev(b, 1'b1), n3);
      if (!n3) rbyte(1'b1, d);
      do_stop();
      nk_any = n1 | n2 | n3;
   endtask

   initial begin
      logic nk;
      logic [7:0] d, lo, hi;
      int w0, k0, rs;
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < 256; a++) begin
            mem[b][a] = init_val(b, a);
            exp_mem[b][a] = init_val(b, a);
         end
      rs = int'($urandom(32'h5EED));
      wq(5);
      rst_n = 1'b1;
      wq(3);
      // R11 reset state
      chk(sda_pull == 1'b0, "R11 sda released", int'(sda_pull), 0);
      chk(reg_wr == 1'b0, "R11 no write", int'(reg_wr), 0);
      // R11 pointer 0: read without setting the pointer
      do_start(); wbyte(dev(1'b0, 1'b1), nk); rbyte(1'b1, d); do_stop();
      chk(!nk && d == exp_mem[0][0], "R11 read at pointer 0", int'(d), int'(exp_mem[0][0]));

      // R3 directed write
      w0 = wr_cnt;
      do_write(1'b0, 8'h05, 8'h5A, nk);
      chk(!nk, "R3 all bytes acked", int'(nk), 0);
      chk(wr_cnt - w0 == 1 && mem[0][8'h05] == 8'h5A, "R3 write landed", int'(mem[0][8'h05]), 8'h5A);
      exp_mem[0][8'h05] = 8'h5A;

      // R2 bank select
      do_write(1'b1, 8'h05, 8'hC3, nk);
      exp_mem[1][8'h05] = 8'hC3;
      do_read(1'b0, 8'h05, d, nk);
      chk(d == 8'h5A, "R2 bank0 keeps its byte", int'(d), 8'h5A);
      do_read(1'b1, 8'h05, d, nk);
      chk(d == 8'hC3, "R2 bank1 byte", int'(d), 8'hC3);

      // R1 wrong strap: no ack, no write
      w0 = wr_cnt;
      do_start(); wbyte({2'b01, 4'b0110, 1'b0, 1'b0}, nk); wbyte(8'h07, nk); wbyte(8'h11, nk); do_stop();
      chk(wr_cnt == w0, "R1 foreign address ignored", wr_cnt - w0, 0);
      do_start(); wbyte({2'b11, STRAP, 1'b0, 1'b0}, nk); do_stop();
      chk(nk == 1'b1, "R1 wrong fixed bits nacked", int'(nk), 1);

      // R4 pointer kept across STOP
      do_start(); wbyte(dev(1'b1, 1'b0), nk); wbyte(8'h77, nk); do_stop();
      do_start(); wbyte(dev(1'b1, 1'b1), nk); rbyte(1'b1, d); do_stop();
      chk(d == exp_mem[1][8'h77], "R4 pointer retained", int'(d), int'(exp_mem[1][8'h77]));

      // R5 write to measurement register
      w0 = wr_cnt;
      do_write(1'b0, 8'h2B, 8'hEE, nk);
      chk(!nk && wr_cnt == w0, "R5 protected write acked, no strobe", wr_cnt - w0, 0);
      chk(mem[0][8'h2B] == exp_mem[0][8'h2B], "R5 content unchanged", int'(mem[0][8'h2B]), int'(exp_mem[0][8'h2B]));

      // R8 single read of measurement register
      k0 = warn_cnt;
      do_read(1'b1, 8'h1B, d, nk);
      chk(d == exp_mem[1][8'h1B], "R8 current byte", int'(d), int'(exp_mem[1][8'h1B]));
      chk(warn_cnt - k0 == 1, "R8 one warn pulse", warn_cnt - k0, 1);

      // R6 pair read with shadow capture
      pair_mode = 1'b1;
      k0 = warn_cnt;
      do_start(); wbyte(dev(1'b1, 1'b0), nk); wbyte(8'h29, nk);
      do_start(); wbyte(dev(1'b1, 1'b1), nk);
      chk(!nk, "R6 pair read acked", int'(nk), 0);
      poke(1'b1, 8'h2A, ~exp_mem[1][8'h2A]);
      rbyte(1'b0, lo); rbyte(1'b1, hi);
      chk(sda_pull == 1'b0, "R6 released after NACK", int'(sda_pull), 0);
      do_stop();
      chk(lo == exp_mem[1][8'h29], "R6 low byte first", int'(lo), int'(exp_mem[1][8'h29]));
      chk(hi == exp_mem[1][8'h2A], "R6 high byte from shadow", int'(hi), int'(exp_mem[1][8'h2A]));
      chk(warn_cnt == k0, "R6 no warn on pair read", warn_cnt - k0, 0);
      exp_mem[1][8'h2A] = ~exp_mem[1][8'h2A];

      // R7 pair read outside window
      do_read(1'b0, 8'h30, d, nk);
      chk(nk == 1'b1, "R7 read address nacked", int'(nk), 1);
      chk(sda_pull == 1'b0, "R7 bus free", int'(sda_pull), 0);
      pair_mode = 1'b0;

      // R9 STOP mid data byte
      w0 = wr_cnt;
      do_start(); wbyte(dev(1'b0, 1'b0), nk); wbyte(8'h05, nk);
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); do_stop();
      chk(wr_cnt == w0, "R9 aborted write", wr_cnt - w0, 0);
      // R9 START mid address byte restarts bit count
      do_start(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      do_write(1'b0, 8'h06, 8'h81, nk);
      chk(!nk && mem[0][8'h06] == 8'h81, "R9 restart after mid-byte START", int'(mem[0][8'h06]), 8'h81);
      exp_mem[0][8'h06] = 8'h81;

      // Random writes and read-back (R3, R5, R4)
      for (int t = 0; t < 30; t++) begin
         logic b;
         logic [7:0] a, dv;
         b  = 1'($urandom_range(0, 1));
         dv = 8'($urandom);
         if ($urandom_range(0, 3) == 0)
            a = {4'($urandom_range(1, 4)), 4'($urandom_range(9, 12))};
         else
            a = 8'($urandom);
         w0 = wr_cnt;
         do_write(b, a, dv, nk);
         if (!is_meas(a)) exp_mem[b][a] = dv;
         chk(!nk && (wr_cnt - w0) == (is_meas(a) ? 0 : 1), "R3/R5 random write strobe", wr_cnt - w0, is_meas(a) ? 0 : 1);
         do_read(b, a, d, nk);
         chk(d == exp_mem[b][a], "R4 random read-back", int'(d), int'(exp_mem[b][a]));
      end

      chk(r10_viol == 0, "R10 pull only while SCL low", r10_viol, 0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule